// File: doc/BRIEF.md
# Counted Loop Fetch Sequencer

This block sits on the fetch side of a processor pipeline and runs a counted loop without any branch instruction inside the loop body. When the decoder meets a loop instruction, it hands over the instruction's own address and two biased fields. The first field is the pass count less three, and the second is the body size in instructions less one. The loop instruction is taken in the early stage and never uses an execute slot. From then on the block produces every fetch address itself. It walks through the body and jumps back to the body start at the end of each pass while passes remain. After the final pass it continues in sequence at the first address past the body.

Once the first pass is complete, the block sends a single prefetch request for the exit address, so the code after the loop is already on its way when the loop ends. A redirect input (exception or taken branch) ends the loop at once and sends fetch to the redirect address. A stall input freezes the block. Only one loop can run at a time. A second loop instruction that arrives while a loop runs is flagged on an error output and otherwise ignored. Instructions are 4 bytes wide.

Top module: `hwloop_seq`

## Requirements
- R1: During and right after a synchronous active-low reset, the fetch address equals the RESET_PC parameter, and active, the remaining-pass count, the prefetch request and the error output are all zero.
- R2: A loop instruction that is accepted (valid while idle, not stalled, not redirected) makes the next fetch address its own address plus 4, raises active, and sets the remaining-pass count to the count field plus 3.
- R3: Inside a pass, the fetch address rises by 4 per unstalled cycle over length field plus 1 instructions. After the last of these it returns to the body start, provided passes remain.
- R4: The remaining-pass count falls by one at each return to the body start. Active stays high for exactly (count field + 3) × (length field + 1) unstalled cycles.
- R5: After the final pass the fetch address is the loop address plus 4 × (length field + 2), active falls, and the remaining-pass count is zero. While active is low, the count is always zero.
- R6: Exactly one one-cycle prefetch request is raised for each loop that completes. It appears in the cycle right after the fetch of the first pass's last instruction, while active is still high, and the prefetch address then equals the exit address.
- R7: While stall is high and there is no redirect, the fetch address, remaining-pass count and body position hold, no prefetch request is raised, and a loop instruction presented is not taken.
- R8: A redirect loads its address as the next fetch address and clears active and the pass count in that same edge. It overrides stall and a loop instruction, and it cancels any prefetch request not yet issued.
- R9: A loop instruction that arrives unstalled while a loop is active raises the error output for one cycle and leaves the running loop's addresses and counts unchanged.
- R10: While idle, unstalled, with no redirect and no loop instruction, the fetch address rises by 4 each cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stall_i | input | 1 | Freeze fetch and loop state |
| loop_valid_i | input | 1 | Decoder presents a loop instruction |
| loop_cnt_i | input | CNT_W | Pass count minus 3 |
| loop_len_i | input | LEN_W | Body length in instructions minus 1 |
| loop_pc_i | input | ADDR_W | Address of the loop instruction |
| redirect_i | input | 1 | Flush or taken branch |
| redirect_pc_i | input | ADDR_W | Target of the redirect |
| pc_o | output | ADDR_W | Current fetch address |
| active_o | output | 1 | A loop is running |
| passes_left_o | output | CNT_W+1 | Passes remaining, including the current one |
| pf_req_o | output | 1 | One-cycle exit-path prefetch request |
| pf_addr_o | output | ADDR_W | Exit address for the prefetch |
| nest_err_o | output | 1 | Loop instruction refused because a loop is active |

## Verification
The bench sweeps every count field from 0 to 4 against every length field from 0 to 4, so it reaches the smallest legal loop (three passes of one instruction). With that coverage, a length or count decoded without its bias shows up as a wrong wrap point, an extra or missing pass, or a wrong exit address. In half of the sweep, stalls land on the last body instruction and on the first instruction of a pass. A design that moves its position counter or fires the prefetch on a stalled cycle would then produce a repeated or skipped address, or a second prefetch pulse. Further directed runs cover the following: a redirect together with stall in the first pass, which must also cancel the coming prefetch; a second loop instruction in the middle of a body, which must not restart the loop; and a loop instruction held during a stall, which must not start anything.

// File: rtl/hwloop_pkg.sv
// Shared constants and types for the counted-loop fetch sequencer.
// Assumes fixed 4-byte instructions.
package hwloop_pkg;
    localparam int INSTR_BYTES = 4;
    localparam int PASS_BIAS   = 3;

    // Source of the next fetch address, decided by the controller.
    typedef enum logic [2:0] {
        NPC_HOLD,
        NPC_SEQ,
        NPC_WRAP,
        NPC_START,
        NPC_REDIR
    } npc_sel_e;
endpackage

// File: rtl/hwloop_decode.sv
// Turns the biased fields of a loop instruction into a real pass count,
// a body start address and an exit address. Purely combinational.
// Assumes the body begins at the instruction right after the loop opcode.
module hwloop_decode #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 5,
    parameter int LEN_W  = 4
) (
    input  logic [CNT_W-1:0]  cnt_field,
    input  logic [LEN_W-1:0]  len_field,
    input  logic [ADDR_W-1:0] op_addr,
    output logic [CNT_W:0]    total_passes,
    output logic [ADDR_W-1:0] body_start,
    output logic [ADDR_W-1:0] exit_addr
);
    import hwloop_pkg::*;
    localparam int PW = CNT_W + 1;

    // Remove the biases and compute both body boundaries.
    always_comb begin
        total_passes = {1'b0, cnt_field} + PW'(PASS_BIAS);
        body_start   = op_addr + ADDR_W'(INSTR_BYTES);
        exit_addr    = op_addr + ADDR_W'({len_field, 2'b00}) + ADDR_W'(2 * INSTR_BYTES);
    end
endmodule

// File: rtl/hwloop_ctrl.sv
// Loop controller: tracks active state, remaining passes and the position
// inside the body, and picks the next-address source each cycle.
// Raises a one-cycle exit prefetch when the first pass ends and flags a
// nested loop instruction. Assumes the pass count is always at least 3.
module hwloop_ctrl #(
    parameter int CNT_W = 5,
    parameter int LEN_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  stall_i,
    input  logic                  loop_valid_i,
    input  logic                  redirect_i,
    input  logic [LEN_W-1:0]      len_field,
    input  logic [CNT_W:0]        total_passes,
    output hwloop_pkg::npc_sel_e  npc_sel,
    output logic                  active_o,
    output logic [CNT_W:0]        passes_left_o,
    output logic                  pf_req_o,
    output logic                  nest_err_o
);
    import hwloop_pkg::*;
    localparam int PW = CNT_W + 1;

    logic [LEN_W-1:0] pos_q;
    logic [LEN_W-1:0] last_pos_q;
    logic             first_pass_q;
    logic             start_w;
    logic             nest_w;
    logic             at_last_w;
    logic             wrap_w;

    // Classify this cycle's events.
    always_comb begin
        start_w   = loop_valid_i && !active_o && !stall_i && !redirect_i;
        nest_w    = loop_valid_i &&  active_o && !stall_i && !redirect_i;
        at_last_w = active_o && (pos_q == last_pos_q);
        wrap_w    = at_last_w && !stall_i && !redirect_i && (passes_left_o != PW'(1));
    end

    // Select the next fetch-address source by priority.
    always_comb begin
        if (redirect_i)   npc_sel = NPC_REDIR;
        else if (stall_i) npc_sel = NPC_HOLD;
        else if (start_w) npc_sel = NPC_START;
        else if (wrap_w)  npc_sel = NPC_WRAP;
        else              npc_sel = NPC_SEQ;
    end

    // Loop state registers: activity, pass count, body position, prefetch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_o      <= 1'b0;
            passes_left_o <= '0;
            pos_q         <= '0;
            last_pos_q    <= '0;
            first_pass_q  <= 1'b0;
            pf_req_o      <= 1'b0;
            nest_err_o    <= 1'b0;
        end else begin
            pf_req_o   <= 1'b0;
            nest_err_o <= nest_w;
            if (redirect_i) begin
                active_o      <= 1'b0;
                passes_left_o <= '0;
                pos_q         <= '0;
                first_pass_q  <= 1'b0;
            end else if (stall_i) begin
                active_o      <= active_o;
            end else if (start_w) begin
                active_o      <= 1'b1;
                passes_left_o <= total_passes;
                pos_q         <= '0;
                last_pos_q    <= len_field;
                first_pass_q  <= 1'b1;
            end else if (active_o) begin
                if (at_last_w) begin
                    pos_q        <= '0;
                    first_pass_q <= 1'b0;
                    pf_req_o     <= first_pass_q;
                    if (passes_left_o == PW'(1)) begin
                        active_o      <= 1'b0;
                        passes_left_o <= '0;
                    end else begin
                        passes_left_o <= passes_left_o - PW'(1);
                    end
                end else begin
                    pos_q <= pos_q + LEN_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/hwloop_pcgen.sv
// Fetch address generator: holds the fetch PC plus the latched body start
// and exit addresses, and updates the PC from the controller's selection.
// Assumes the selection already resolves redirect and stall priority.
module hwloop_pcgen #(
    parameter int              ADDR_W   = 32,
    parameter logic [ADDR_W-1:0] RESET_PC = 32'h0000_0100
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  hwloop_pkg::npc_sel_e npc_sel,
    input  logic [ADDR_W-1:0]    dec_start,
    input  logic [ADDR_W-1:0]    dec_exit,
    input  logic [ADDR_W-1:0]    redirect_pc_i,
    output logic [ADDR_W-1:0]    pc_o,
    output logic [ADDR_W-1:0]    exit_q
);
    import hwloop_pkg::*;

    logic [ADDR_W-1:0] start_q;

    // Advance, hold, wrap or reload the fetch address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_o    <= RESET_PC;
            start_q <= '0;
            exit_q  <= '0;
        end else begin
            case (npc_sel)
                NPC_REDIR: pc_o <= redirect_pc_i;
                NPC_HOLD:  pc_o <= pc_o;
                NPC_START: begin
                    pc_o    <= dec_start;
                    start_q <= dec_start;
                    exit_q  <= dec_exit;
                end
                NPC_WRAP:  pc_o <= start_q;
                default:   pc_o <= pc_o + ADDR_W'(INSTR_BYTES);
            endcase
        end
    end
endmodule

// File: rtl/hwloop_seq.sv
// Top of the counted-loop fetch sequencer. Absorbs a loop instruction in
// the early stage and generates all body and exit fetch addresses.
// Assumes one loop at a time and 4-byte instructions.
module hwloop_seq #(
    parameter int                ADDR_W   = 32,
    parameter int                CNT_W    = 5,
    parameter int                LEN_W    = 4,
    parameter logic [ADDR_W-1:0] RESET_PC = 32'h0000_0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall_i,
    input  logic              loop_valid_i,
    input  logic [CNT_W-1:0]  loop_cnt_i,
    input  logic [LEN_W-1:0]  loop_len_i,
    input  logic [ADDR_W-1:0] loop_pc_i,
    input  logic              redirect_i,
    input  logic [ADDR_W-1:0] redirect_pc_i,
    output logic [ADDR_W-1:0] pc_o,
    output logic              active_o,
    output logic [CNT_W:0]    passes_left_o,
    output logic              pf_req_o,
    output logic [ADDR_W-1:0] pf_addr_o,
    output logic              nest_err_o
);
    import hwloop_pkg::*;

    logic [CNT_W:0]    total_passes;
    logic [ADDR_W-1:0] dec_start;
    logic [ADDR_W-1:0] dec_exit;
    npc_sel_e          npc_sel;

    hwloop_decode #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .LEN_W(LEN_W)) u_decode (
        .cnt_field    (loop_cnt_i),
        .len_field    (loop_len_i),
        .op_addr      (loop_pc_i),
        .total_passes (total_passes),
        .body_start   (dec_start),
        .exit_addr    (dec_exit)
    );

    hwloop_ctrl #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .stall_i       (stall_i),
        .loop_valid_i  (loop_valid_i),
        .redirect_i    (redirect_i),
        .len_field     (loop_len_i),
        .total_passes  (total_passes),
        .npc_sel       (npc_sel),
        .active_o      (active_o),
        .passes_left_o (passes_left_o),
        .pf_req_o      (pf_req_o),
        .nest_err_o    (nest_err_o)
    );

    hwloop_pcgen #(.ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) u_pcgen (
        .clk           (clk),
        .rst_n         (rst_n),
        .npc_sel       (npc_sel),
        .dec_start     (dec_start),
        .dec_exit      (dec_exit),
        .redirect_pc_i (redirect_pc_i),
        .pc_o          (pc_o),
        .exit_q        (pf_addr_o)
    );
endmodule

// File: rtl/hwloop_chk.sv
// Property checker for the loop sequencer, bound to the top module.
// Relates port behaviour across cycles; assumes synchronous reset.
module hwloop_chk #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stall_i,
    input logic              loop_valid_i,
    input logic [CNT_W-1:0]  loop_cnt_i,
    input logic [ADDR_W-1:0] loop_pc_i,
    input logic              redirect_i,
    input logic [ADDR_W-1:0] redirect_pc_i,
    input logic [ADDR_W-1:0] pc_o,
    input logic              active_o,
    input logic [CNT_W:0]    passes_left_o,
    input logic              pf_req_o,
    input logic              nest_err_o
);
    localparam int PW = CNT_W + 1;

    assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_valid_i && !active_o && !stall_i && !redirect_i) |=>
        (active_o && passes_left_o == $past({1'b0, loop_cnt_i}) + PW'(3)
         && pc_o == $past(loop_pc_i) + ADDR_W'(4)));

    assert_idle_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !active_o |-> (passes_left_o == '0));

    assert_pf_in_loop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pf_req_o |-> active_o);

    assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_i && !redirect_i) |=>
        ($stable(pc_o) && $stable(passes_left_o) && $stable(active_o) && !pf_req_o));

    assert_redirect_R8: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_i |=> (pc_o == $past(redirect_pc_i) && !active_o));

    assert_nest_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_valid_i && active_o && !stall_i && !redirect_i) |=> nest_err_o);

    assert_idle_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_o && !stall_i && !redirect_i && !loop_valid_i) |=>
        (pc_o == $past(pc_o) + ADDR_W'(4)));
endmodule

bind hwloop_seq hwloop_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .stall_i       (stall_i),
    .loop_valid_i  (loop_valid_i),
    .loop_cnt_i    (loop_cnt_i),
    .loop_pc_i     (loop_pc_i),
    .redirect_i    (redirect_i),
    .redirect_pc_i (redirect_pc_i),
    .pc_o          (pc_o),
    .active_o      (active_o),
    .passes_left_o (passes_left_o),
    .pf_req_o      (pf_req_o),
    .nest_err_o    (nest_err_o)
);

// File: tb/tb_hwloop_seq.sv
// Self-checking bench: sweeps small count/length fields, then directed
// stall, redirect and nesting cases. Expected values come from arithmetic.
module tb_hwloop_seq;
    localparam int ADDR_W = 32;
    localparam int CNT_W  = 5;
    localparam int LEN_W  = 4;
    localparam logic [31:0] RST_PC = 32'h0000_0100;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              stall_i = 1'b0;
    logic              loop_valid_i = 1'b0;
    logic [CNT_W-1:0]  loop_cnt_i = '0;
    logic [LEN_W-1:0]  loop_len_i = '0;
    logic [ADDR_W-1:0] loop_pc_i = '0;
    logic              redirect_i = 1'b0;
    logic [ADDR_W-1:0] redirect_pc_i = '0;
    logic [ADDR_W-1:0] pc_o;
    logic              active_o;
    logic [CNT_W:0]    passes_left_o;
    logic              pf_req_o;
    logic [ADDR_W-1:0] pf_addr_o;
    logic              nest_err_o;

    int total = 0;
    int fails = 0;

    hwloop_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .LEN_W(LEN_W), .RESET_PC(RST_PC)) dut (
        .clk(clk), .rst_n(rst_n), .stall_i(stall_i), .loop_valid_i(loop_valid_i),
        .loop_cnt_i(loop_cnt_i), .loop_len_i(loop_len_i), .loop_pc_i(loop_pc_i),
        .redirect_i(redirect_i), .redirect_pc_i(redirect_pc_i), .pc_o(pc_o),
        .active_o(active_o), .passes_left_o(passes_left_o), .pf_req_o(pf_req_o),
        .pf_addr_o(pf_addr_o), .nest_err_o(nest_err_o)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // One clock edge, then settle away from the edge.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Run one full loop and check every fetched address.
    task automatic run_loop(input int cnt, input int len, input logic [31:0] base, input bit use_stall);
        int P = cnt + 3;
        int L = len + 1;
        int pf_seen = 0;
        int issued = 0;
        logic [31:0] ex = base + 32'(4 * (len + 2));
        logic [31:0] hold_pc;
        loop_valid_i = 1'b1; loop_pc_i = base;
        loop_cnt_i = CNT_W'(cnt); loop_len_i = LEN_W'(len);
        step();
        loop_valid_i = 1'b0;
        chk(active_o && pc_o == base + 4 && passes_left_o == (CNT_W+1)'(P), "R2 start",
            {32'd0, pc_o}, {32'd0, base + 32'd4});
        for (int p = 0; p < P; p++) begin
            for (int i = 0; i < L; i++) begin
                chk(pc_o == base + 32'(4 + 4 * i), "R3 body address", pc_o, base + 32'(4 + 4 * i));
                chk(active_o && passes_left_o == (CNT_W+1)'(P - p), "R4 passes left",
                    passes_left_o, 64'(P - p));
                if (use_stall && ((p + i) % 3 == 1)) begin
                    hold_pc = pc_o;
                    stall_i = 1'b1; step(); stall_i = 1'b0;
                    chk(pc_o == hold_pc && passes_left_o == (CNT_W+1)'(P - p) && !pf_req_o,
                        "R7 stall hold", pc_o, hold_pc);
                end
                if (active_o) issued++;
                step();
                if (pf_req_o) begin
                    pf_seen++;
                    chk(p == 0 && i == L - 1 && active_o, "R6 prefetch timing", 64'(p * 100 + i), 64'(L - 1));
                    chk(pf_addr_o == ex, "R6 prefetch address", pf_addr_o, ex);
                end
            end
        end
        chk(!active_o && pc_o == ex && passes_left_o == '0, "R5 exit", pc_o, ex);
        chk(pf_seen == 1, "R6 one prefetch", 64'(pf_seen), 64'd1);
        chk(issued == P * L, "R4 issued count", 64'(issued), 64'(P * L));
    endtask

    initial begin
        #(10 * 150000);
        fails++; total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [31:0] q;
        logic [31:0] b;
        repeat (3) step();
        chk(pc_o == RST_PC && !active_o && passes_left_o == '0 && !pf_req_o && !nest_err_o,
            "R1 reset state", pc_o, RST_PC);
        rst_n = 1'b1;
        step();
        chk(pc_o == RST_PC + 4, "R10 idle step", pc_o, RST_PC + 4);
        for (int k = 0; k < 3; k++) begin
            q = pc_o; step();
            chk(pc_o == q + 4 && !active_o, "R10 idle step", pc_o, q + 4);
        end

        // Stall in idle with a loop instruction presented: nothing taken.
        q = pc_o;
        stall_i = 1'b1; loop_valid_i = 1'b1; loop_pc_i = 32'h4000; step();
        stall_i = 1'b0; loop_valid_i = 1'b0;
        chk(pc_o == q && !active_o, "R7 loop ignored during stall", pc_o, q);

        // Full sweep of small field values.
        for (int c = 0; c < 5; c++)
            for (int l = 0; l < 5; l++)
                run_loop(c, l, 32'h1000 + 32'(256 * (c * 5 + l)), ((c + l) % 2) == 1);

        // Redirect with stall in the first pass cancels loop and prefetch.
        loop_valid_i = 1'b1; loop_pc_i = 32'h6000; loop_cnt_i = 5'd1; loop_len_i = 4'd3;
        step(); loop_valid_i = 1'b0;
        repeat (3) step();
        redirect_i = 1'b1; redirect_pc_i = 32'h8000; stall_i = 1'b1; step();
        redirect_i = 1'b0; stall_i = 1'b0;
        chk(pc_o == 32'h8000 && !active_o && passes_left_o == '0, "R8 redirect", pc_o, 32'h8000);
        for (int k = 1; k <= 6; k++) begin
            step();
            chk(!pf_req_o && pc_o == 32'h8000 + 32'(4 * k), "R8 no prefetch after redirect",
                pc_o, 32'h8000 + 32'(4 * k));
        end

        // Redirect wins over a loop instruction in idle.
        loop_valid_i = 1'b1; loop_pc_i = 32'h7000; redirect_i = 1'b1; redirect_pc_i = 32'h9000;
        step(); loop_valid_i = 1'b0; redirect_i = 1'b0;
        chk(pc_o == 32'h9000 && !active_o, "R8 redirect over loop start", pc_o, 32'h9000);

        // Nested loop instruction during a body.
        b = 32'hA000;
        loop_valid_i = 1'b1; loop_pc_i = b; loop_cnt_i = 5'd0; loop_len_i = 4'd1;
        step();
        loop_pc_i = 32'hB000; loop_cnt_i = 5'd9; loop_len_i = 4'd7;
        step(); loop_valid_i = 1'b0;
        chk(nest_err_o && pc_o == b + 8 && passes_left_o == 6'd3, "R9 nested flagged", pc_o, b + 8);
        step();
        chk(!nest_err_o && pc_o == b + 4 && passes_left_o == 6'd2 && pf_req_o && pf_addr_o == b + 12,
            "R9 loop unaffected", pc_o, b + 4);
        repeat (4) step();
        chk(!active_o && pc_o == b + 12, "R9 original exit", pc_o, b + 12);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule